// File: doc/BRIEF.md
# Overscan Border Window Generator

This block sits on a display pixel stream and draws an overscan border around a rectangle of placed content. Configuration gives the active area size and the content rectangle: origin and extent. From these the block derives the four border thicknesses. Two counters follow the raster during active video: a column count that restarts at each line start, and a row count that restarts at each frame start. Every pixel is classed as inside the content window or as border. Border pixels are replaced by a programmable colour, and window pixels pass through unchanged.

The right and bottom borders are what is left of the active size once the rectangle's origin and extent are taken out. A debug widening option adds two pixels to each of them. A result below zero is clamped to zero and sets a sticky error flag. All border values and the border colour are captured only at frame start, so a configuration change made partway through a frame takes effect at the next frame.

Top module: `overscan_window`

## Requirements
- R1: After reset `pix_out` is 0 and both `inside_out` and `cfg_err` are 0. Until the first `frame_start`, no pixel is classed as inside.
- R2: The left border equals `cfg_win_x` and the top border equals `cfg_win_y`. A pixel whose column is below the left border, or whose row is below the top border, is border.
- R3: The right border is `cfg_h_active - cfg_win_x - cfg_win_w`. A pixel whose column is at or beyond `cfg_h_active` minus the right border is border.
- R4: The bottom border is `cfg_v_active - cfg_win_y - cfg_win_h`. A pixel whose row is at or beyond `cfg_v_active` minus the bottom border is border.
- R5: While `cfg_dbg_widen` is 1 at frame start, the right and bottom borders are each 2 larger than the values in R3 and R4. The widening is applied before the clamp in R6.
- R6: A right or bottom border that computes below zero is clamped to 0, so the window reaches the edge of the active area. A window right or bottom edge that computes below zero is also clamped to 0.
- R7: `cfg_err` rises at the frame start whose right or bottom border (after widening) computes below zero. It then stays 1 until reset.
- R8: The borders and the border colour are captured only in a cycle with `frame_start` high. They take effect from the next cycle. Configuration changes at any other time have no effect on the output.
- R9: The column counter is 0 for a pixel in the line start cycle and counts `de_in` cycles since the last `line_start`. It holds while `de_in` is low. The row counter is 0 after `frame_start` and advances at a `line_start` only if the previous line contained at least one `de_in` cycle.
- R10: Outputs are registered with one cycle of latency. `inside_out` is 1 only for a cycle that follows an input cycle with `de_in` high on a window pixel. For every other input cycle, `pix_out` carries the captured border colour.
- R11: For a window pixel, `pix_out` equals the `pix_in` value of the previous cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Pixel clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| cfg_h_active | input | CW | Active pixels per line |
| cfg_v_active | input | CW | Active lines per frame |
| cfg_win_x | input | CW | Content rectangle left column |
| cfg_win_y | input | CW | Content rectangle top row |
| cfg_win_w | input | CW | Content rectangle width |
| cfg_win_h | input | CW | Content rectangle height |
| cfg_dbg_widen | input | 1 | Widen right and bottom borders by 2 |
| cfg_border_color | input | PW | Colour used for border pixels |
| frame_start | input | 1 | One-cycle frame start strobe |
| line_start | input | 1 | One-cycle line start strobe |
| de_in | input | 1 | Data enable for the incoming pixel |
| pix_in | input | PW | Incoming pixel |
| pix_out | output | PW | Pixel or border colour, one cycle later |
| inside_out | output | 1 | Output pixel lies inside the content window |
| cfg_err | output | 1 | Sticky flag: a border computed negative |

## Verification
A wrong border edge register shows up at the ports on the first active line of the next frame that crosses that edge. The output flips between the border colour and the passed pixel exactly one cycle after the offending input pixel. A counter slip shows up the same way, and the error persists for the rest of the line or frame. A clamp or error-flag fault is visible one cycle after the frame start that captures an overflowing rectangle. The random frames change the configuration inputs partway through each frame, so any capture outside frame start is detected within the same frame.

// File: rtl/overscan_window.sv
module overscan_window #(
  parameter int CW      = 12,
  parameter int PW      = 24,
  parameter int DBG_PAD = 2
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [CW-1:0] cfg_h_active,
  input  logic [CW-1:0] cfg_v_active,
  input  logic [CW-1:0] cfg_win_x,
  input  logic [CW-1:0] cfg_win_y,
  input  logic [CW-1:0] cfg_win_w,
  input  logic [CW-1:0] cfg_win_h,
  input  logic          cfg_dbg_widen,
  input  logic [PW-1:0] cfg_border_color,
  input  logic          frame_start,
  input  logic          line_start,
  input  logic          de_in,
  input  logic [PW-1:0] pix_in,
  output logic [PW-1:0] pix_out,
  output logic          inside_out,
  output logic          cfg_err
);
  localparam int SW = CW + 3;

  logic [SW-1:0] pad, rgt_raw, bot_raw, rgt_cl, bot_cl, r_edge_raw, b_edge_raw;
  logic [CW-1:0] l_edge_q, t_edge_q, r_edge_q, b_edge_q;
  logic [PW-1:0] bc_q;
  logic [CW-1:0] col_q, row_q, col_cur, row_cur;
  logic          seen_q, in_win;

  assign pad     = cfg_dbg_widen ? SW'(DBG_PAD) : '0;
  assign rgt_raw = SW'(cfg_h_active) - SW'(cfg_win_x) - SW'(cfg_win_w) + pad;
  assign bot_raw = SW'(cfg_v_active) - SW'(cfg_win_y) - SW'(cfg_win_h) + pad;
  assign rgt_cl  = rgt_raw[SW-1] ? '0 : rgt_raw;
  assign bot_cl  = bot_raw[SW-1] ? '0 : bot_raw;
  assign r_edge_raw = SW'(cfg_h_active) - rgt_cl;
  assign b_edge_raw = SW'(cfg_v_active) - bot_cl;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      l_edge_q <= '0;
      t_edge_q <= '0;
      r_edge_q <= '0;
      b_edge_q <= '0;
      bc_q     <= '0;
      cfg_err  <= 1'b0;
    end else if (frame_start) begin
      l_edge_q <= cfg_win_x;
      t_edge_q <= cfg_win_y;
      r_edge_q <= r_edge_raw[SW-1] ? '0 : r_edge_raw[CW-1:0];
      b_edge_q <= b_edge_raw[SW-1] ? '0 : b_edge_raw[CW-1:0];
      bc_q     <= cfg_border_color;
      if (rgt_raw[SW-1] || bot_raw[SW-1]) cfg_err <= 1'b1;
    end
  end

  assign col_cur = (line_start || frame_start) ? '0 : col_q;
  assign row_cur = frame_start ? '0 : ((line_start && seen_q) ? row_q + 1'b1 : row_q);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      col_q  <= '0;
      row_q  <= '0;
      seen_q <= 1'b0;
    end else begin
      col_q  <= de_in ? col_cur + 1'b1 : col_cur;
      row_q  <= row_cur;
      seen_q <= (line_start || frame_start) ? de_in : (seen_q || de_in);
    end
  end

  assign in_win = de_in && (col_cur >= l_edge_q) && (col_cur < r_edge_q) &&
                  (row_cur >= t_edge_q) && (row_cur < b_edge_q);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pix_out    <= '0;
      inside_out <= 1'b0;
    end else begin
      pix_out    <= in_win ? pix_in : bc_q;
      inside_out <= in_win;
    end
  end
endmodule

module overscan_window_chk #(
  parameter int CW = 12,
  parameter int PW = 24
) (
  input logic          clk,
  input logic          rst_n,
  input logic          frame_start,
  input logic          de_in,
  input logic [PW-1:0] pix_in,
  input logic [CW-1:0] cfg_h_active,
  input logic [CW-1:0] cfg_v_active,
  input logic [PW-1:0] pix_out,
  input logic          inside_out,
  input logic          cfg_err,
  input logic [CW-1:0] l_edge_q,
  input logic [CW-1:0] r_edge_q,
  input logic [CW-1:0] b_edge_q
);
  assert_pass_through_R11: assert property (@(posedge clk) disable iff (!rst_n)
    inside_out |-> pix_out == $past(pix_in));

  assert_de_gate_R10: assert property (@(posedge clk) disable iff (!rst_n)
    !de_in |=> !inside_out);

  assert_err_sticky_R7: assert property (@(posedge clk) disable iff (!rst_n)
    cfg_err |=> cfg_err);

  assert_edge_clamp_R6: assert property (@(posedge clk) disable iff (!rst_n)
    frame_start |=> (r_edge_q <= $past(cfg_h_active)) && (b_edge_q <= $past(cfg_v_active)));

  assert_edge_hold_R8: assert property (@(posedge clk) disable iff (!rst_n)
    !frame_start |=> $stable(l_edge_q) && $stable(r_edge_q) && $stable(b_edge_q));
endmodule

bind overscan_window overscan_window_chk #(.CW(CW), .PW(PW)) u_chk (
  .clk(clk), .rst_n(rst_n), .frame_start(frame_start), .de_in(de_in),
  .pix_in(pix_in), .cfg_h_active(cfg_h_active), .cfg_v_active(cfg_v_active),
  .pix_out(pix_out), .inside_out(inside_out), .cfg_err(cfg_err),
  .l_edge_q(l_edge_q), .r_edge_q(r_edge_q), .b_edge_q(b_edge_q)
);

// File: tb/overscan_window_tb.sv
`timescale 1ns/1ps
module overscan_window_tb;
  localparam int CW = 12;
  localparam int PW = 24;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic [CW-1:0] h_act, v_act, wx, wy, ww, wh;
  logic dbg;
  logic [PW-1:0] bcol;
  logic fs, ls, de;
  logic [PW-1:0] pix;
  logic [PW-1:0] pix_out;
  logic inside_out, cfg_err;

  always #4 clk = ~clk;

  overscan_window #(.CW(CW), .PW(PW)) u_dut (
    .clk(clk), .rst_n(rst_n), .cfg_h_active(h_act), .cfg_v_active(v_act),
    .cfg_win_x(wx), .cfg_win_y(wy), .cfg_win_w(ww), .cfg_win_h(wh),
    .cfg_dbg_widen(dbg), .cfg_border_color(bcol), .frame_start(fs),
    .line_start(ls), .de_in(de), .pix_in(pix), .pix_out(pix_out),
    .inside_out(inside_out), .cfg_err(cfg_err));

  int checks = 0, fails = 0;
  string tag = "R1";

  int m_col, m_row, m_l, m_t, m_re, m_be;
  bit m_seen, m_err, pend;
  logic [PW-1:0] m_bc, e_pix;
  bit e_in, e_err;

  task automatic check(input string t, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h at %0t", t, act, exp, $time);
    end
  endtask

  function automatic bit border_neg(input int a, input int o, input int e, input bit d);
    return (a - o - e + (d ? 2 : 0)) < 0;
  endfunction

  function automatic int edge_of(input int a, input int o, input int e, input bit d);
    int b, r;
    b = a - o - e + (d ? 2 : 0);
    if (b < 0) b = 0;
    r = a - b;
    return (r < 0) ? 0 : r;
  endfunction

  task automatic do_reset();
    @(negedge clk);
    rst_n = 1'b0; fs = 0; ls = 0; de = 0; pix = '0;
    pend = 0; m_col = 0; m_row = 0; m_l = 0; m_t = 0; m_re = 0; m_be = 0;
    m_seen = 0; m_err = 0; m_bc = '0;
    repeat (3) @(negedge clk);
    check("R1 pix_out", 64'(pix_out), 64'd0);
    check("R1 inside_out", 64'(inside_out), 64'd0);
    check("R1 cfg_err", 64'(cfg_err), 64'd0);
    rst_n = 1'b1;
  endtask

  task automatic tick(input bit l, input bit f, input bit d, input logic [PW-1:0] p);
    int cc, rc;
    @(negedge clk);
    if (pend) begin
      check({tag, " inside_out"}, 64'(inside_out), 64'(e_in));
      check({tag, " pix_out"}, 64'(pix_out), 64'(e_pix));
      check("R7 cfg_err", 64'(cfg_err), 64'(e_err));
    end
    ls = l; fs = f; de = d; pix = p;
    cc = (l || f) ? 0 : m_col;
    rc = f ? 0 : ((l && m_seen) ? m_row + 1 : m_row);
    e_in = d && cc >= m_l && cc < m_re && rc >= m_t && rc < m_be;
    e_pix = e_in ? p : m_bc;
    if (f && (border_neg(h_act, wx, ww, dbg) || border_neg(v_act, wy, wh, dbg))) m_err = 1;
    e_err = m_err;
    if (f) begin
      m_l = wx; m_t = wy; m_bc = bcol;
      m_re = edge_of(h_act, wx, ww, dbg);
      m_be = edge_of(v_act, wy, wh, dbg);
    end
    m_col = d ? cc + 1 : cc;
    m_row = rc;
    m_seen = (l || f) ? d : (m_seen || d);
    pend = 1;
  endtask

  task automatic frame(input int lines, input int px, input bit gaps, input bit junk);
    tick(0, 1, 0, '0);
    tick(0, 0, 0, '0);
    for (int ln = 0; ln < lines; ln++) begin
      tick(1, 0, 0, '0);
      for (int c = 0; c < px; c++) begin
        if (gaps && ($urandom % 5 == 0)) tick(0, 0, 0, PW'($urandom));
        tick(0, 0, 1, PW'($urandom));
      end
      tick(0, 0, 0, '0);
      if (junk && ln == 0) begin
        // R8: configuration churn mid-frame must not change this frame
        wx = CW'($urandom % 30); ww = CW'($urandom % 30); wy = CW'($urandom % 9);
        wh = CW'($urandom % 9); dbg = $urandom % 2; bcol = PW'($urandom);
      end
    end
    tick(0, 0, 0, '0);
  endtask

  initial begin
    #(8ns * 200000);
    fails++;
    $display("FAIL watchdog expired");
    $display("  TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    void'($urandom(32'd2024));
    h_act = 16; v_act = 6; wx = 3; wy = 1; ww = 8; wh = 3; dbg = 0; bcol = 24'h00FF00;
    do_reset();
    tag = "R1";
    tick(1, 0, 1, 24'h123456);
    tick(0, 0, 1, 24'h654321);
    tag = "R2 R3 R4 R11";
    frame(6, 16, 0, 0);
    tag = "R9";
    frame(6, 16, 1, 0);
    tag = "R5";
    dbg = 1;
    frame(6, 16, 0, 0);
    tag = "R6";
    dbg = 0; wx = 10; ww = 12; wy = 2; wh = 9;
    frame(6, 16, 0, 0);
    tag = "R7";
    wx = 0; ww = 16; wy = 0; wh = 6; dbg = 1;
    frame(6, 16, 0, 0);
    dbg = 0; wx = 2; ww = 4;
    frame(3, 16, 0, 0);
    do_reset();
    tag = "R8 R10";
    for (int i = 0; i < 30; i++) begin
      h_act = CW'(8 + $urandom % 33); v_act = CW'(3 + $urandom % 10);
      wx = CW'($urandom % 20); ww = CW'($urandom % 35);
      wy = CW'($urandom % 6); wh = CW'($urandom % 12);
      dbg = ($urandom % 4) == 0; bcol = PW'($urandom);
      frame(int'(v_act), int'(h_act), i % 2 == 1, 1);
    end
    tick(0, 0, 0, '0);
    $display("  TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule